// File: doc/BRIEF.md
# Masked Time-of-Day Alarm Comparator

This block holds the alarm setting of a real-time timekeeper and decides when the alarm goes off. Three 8-bit alarm registers (minutes, hours, day of week) sit on a small register bus. Each register carries an enable-to-ignore mask in its top bit, and the value fields use the same BCD layout as the running time fields. The hours layout includes the 12/24-hour select bit and the AM/PM or twenty-hours bit.

The timekeeper supplies its running minutes, hours and day fields. It also supplies two level inputs. One marks the interval in which hundredths read 99. The other marks that seconds read 59. The comparison is made only while both are high, which is the step in which the minute rolls over. On a hit the block sets a sticky alarm flag and pulls its active-low interrupt low. Any bus read or write of an alarm register clears both.

The masks nest. Ignoring the day gives a daily alarm, ignoring day and hours gives an hourly one, and ignoring all three fires at every minute boundary.

Top module: `tod_alarm_cmp`

## Requirements
- R1: Bus address 0 selects the minutes alarm register, address 1 the hours alarm register and address 2 the day alarm register. A write (`bus_en`=1, `bus_wr`=1) stores `bus_wdata`. Bit 7 of each register is its mask bit. `bus_rdata` shows the register addressed by `bus_addr` combinationally. Minutes and hours read back all 8 bits as written.
- R2: Bits 6 to 3 of the day alarm register always read 0, whatever was written. Bits 2 to 0 hold the day and bit 7 holds the mask.
- R3: With all three mask bits 0, a check fires only when minutes, hours (all 7 bits) and day (3 bits) all equal their alarm values.
- R4: The day mask (bit 7 of address 2) makes the day field ignored. The alarm then fires when minutes and hours match.
- R5: With the day and hours masks both set, only minutes are compared. The hours mask has no effect unless the day mask is also set.
- R6: With all three masks set, every check fires. The minutes mask has no effect unless both other masks are set.
- R7: A check is made only at a rising clock edge where `hund99` and `sec59` are both 1. A hit sets `alarm_flag` at that edge. After a fire, no further fire occurs until `hund99` has been low at a clock edge.
- R8: `alarm_flag` is sticky until cleared. `alarm_irq_n` is its active-low copy.
- R9: Any bus access (read or write) to addresses 0 to 2 clears `alarm_flag` at that edge. An access wins over a hit in the same cycle. Address 3 reads as 0, ignores writes and does not clear the flag.
- R10: After reset all three alarm registers read 0, `alarm_flag` is 0 and `alarm_irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select: 0 minutes, 1 hours, 2 day |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| cur_min | input | 7 | Running minutes, BCD |
| cur_hour | input | 7 | Running hours, BCD with 12/24 and AM/PM bits |
| cur_day | input | 3 | Running day of week |
| hund99 | input | 1 | High while hundredths read 99 |
| sec59 | input | 1 | High while seconds read 59 |
| alarm_flag | output | 1 | Sticky alarm flag |
| alarm_irq_n | output | 1 | Active-low alarm interrupt |

## Verification
The bench sweeps all eight mask combinations against all eight patterns of which time fields match. A design that nests the masks wrongly, or treats each mask independently, would fire on the wrong patterns. It also holds the check window open across several cycles and clears the flag in the middle of it. A design without the once-per-window guard would fire again at once. Further cases are an access in the same cycle as a hit, which must leave the flag clear, an access to the unused address, which must leave the flag set, and a day write of all ones, which must read back with bits 6 to 3 cleared.

// File: rtl/tda_alarm_pkg.sv
package tda_alarm_pkg;

    localparam int REG_W    = 8;
    localparam int MASK_BIT = REG_W - 1;
    localparam int MIN_W    = 7;
    localparam int HR_W     = 7;
    localparam int DAY_W    = 3;
    localparam int ADDR_W   = 2;

    localparam logic [ADDR_W-1:0] A_MIN  = 2'd0;
    localparam logic [ADDR_W-1:0] A_HOUR = 2'd1;
    localparam logic [ADDR_W-1:0] A_DAY  = 2'd2;

    typedef struct packed {
        logic             m_mask;
        logic [MIN_W-1:0] m_val;
        logic             h_mask;
        logic [HR_W-1:0]  h_val;
        logic             d_mask;
        logic [DAY_W-1:0] d_val;
    } alm_regs_t;

endpackage

// File: rtl/tda_alarm_regs.sv
module tda_alarm_regs
    import tda_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output alm_regs_t         regs
);

    alm_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (bus_en && bus_wr) begin
            unique case (bus_addr)
                A_MIN: begin
                    regs_d.m_mask = bus_wdata[MASK_BIT];
                    regs_d.m_val  = bus_wdata[MIN_W-1:0];
                end
                A_HOUR: begin
                    regs_d.h_mask = bus_wdata[MASK_BIT];
                    regs_d.h_val  = bus_wdata[HR_W-1:0];
                end
                A_DAY: begin
                    regs_d.d_mask = bus_wdata[MASK_BIT];
                    regs_d.d_val  = bus_wdata[DAY_W-1:0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_MIN: begin
                bus_rdata[MASK_BIT]  = regs_q.m_mask;
                bus_rdata[MIN_W-1:0] = regs_q.m_val;
            end
            A_HOUR: begin
                bus_rdata[MASK_BIT] = regs_q.h_mask;
                bus_rdata[HR_W-1:0] = regs_q.h_val;
            end
            A_DAY: begin
                bus_rdata[MASK_BIT]  = regs_q.d_mask;
                bus_rdata[DAY_W-1:0] = regs_q.d_val;
            end
            default: ;
        endcase
    end

    assign regs = regs_q;

    // R2: unused day bits never read as anything but zero
    a_r2_day_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_DAY) |-> (bus_rdata[MASK_BIT-1:DAY_W] == '0));

    // R1: a write lands in the addressed register by the next cycle
    a_r1_min_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_wr && bus_addr == A_MIN) |=>
            ({regs_q.m_mask, regs_q.m_val} == $past(bus_wdata)));

endmodule

// File: rtl/tda_alarm_match.sv
module tda_alarm_match
    import tda_alarm_pkg::*;
(
    input  alm_regs_t         regs,
    input  logic [MIN_W-1:0]  cur_min,
    input  logic [HR_W-1:0]   cur_hour,
    input  logic [DAY_W-1:0]  cur_day,
    output logic              hit
);

    logic skip_day, skip_hour, skip_min;
    logic eq_day, eq_hour, eq_min;

    always_comb begin
        // nested masks: each level only counts when the wider one is set
        skip_day  = regs.d_mask;
        skip_hour = regs.d_mask && regs.h_mask;
        skip_min  = skip_hour && regs.m_mask;
        eq_day    = (cur_day  == regs.d_val);
        eq_hour   = (cur_hour == regs.h_val);
        eq_min    = (cur_min  == regs.m_val);
        hit       = (skip_day || eq_day) && (skip_hour || eq_hour) &&
                    (skip_min || eq_min);
    end

endmodule

// File: rtl/tod_alarm_cmp.sv
module tod_alarm_cmp
    import tda_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic [MIN_W-1:0]  cur_min,
    input  logic [HR_W-1:0]   cur_hour,
    input  logic [DAY_W-1:0]  cur_day,
    input  logic              hund99,
    input  logic              sec59,
    output logic              alarm_flag,
    output logic              alarm_irq_n
);

    typedef struct packed {
        logic flag;
        logic done;
    } evt_state_t;

    alm_regs_t  regs;
    logic       hit;
    logic       bus_hit;
    logic       fire;
    evt_state_t st_d, st_q;

    tda_alarm_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .regs      (regs)
    );

    tda_alarm_match u_match (
        .regs     (regs),
        .cur_min  (cur_min),
        .cur_hour (cur_hour),
        .cur_day  (cur_day),
        .hit      (hit)
    );

    always_comb begin
        st_d    = st_q;
        bus_hit = bus_en && (bus_addr <= A_DAY);
        fire    = hund99 && sec59 && hit && !st_q.done;
        st_d.done = hund99 ? (st_q.done || fire) : 1'b0;
        st_d.flag = bus_hit ? 1'b0 : (st_q.flag || fire);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign alarm_flag  = st_q.flag;
    assign alarm_irq_n = !st_q.flag;

    // R9: access clears the flag at that edge
    a_r9_access_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_addr != 2'd3) |=> !alarm_flag);

    // R7: flag only rises from a matching check window
    a_r7_rise_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm_flag) |-> $past(hund99 && sec59 && hit));

    // R7: no second fire while the same window stays open
    a_r7_once_per_window: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.done && hund99 && !bus_en) |=> $stable(alarm_flag));

    // R8: flag holds without an access
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_flag && !bus_en) |=> alarm_flag);

    // R8: interrupt is the inverse of the flag
    a_r8_irq_polarity: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_irq_n != alarm_flag);

endmodule

// File: tb/sim_tod_alarm_cmp.sv
module sim_tod_alarm_cmp;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_en = 1'b0, bus_wr = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [6:0] cur_min = '0, cur_hour = '0;
    logic [2:0] cur_day = '0;
    logic       hund99 = 1'b0, sec59 = 1'b0;
    logic       alarm_flag, alarm_irq_n;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    always #5 clk = ~clk;

    tod_alarm_cmp u0 (
        .clk(clk), .rst_n(rst_n),
        .bus_en(bus_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cur_min(cur_min), .cur_hour(cur_hour), .cur_day(cur_day),
        .hund99(hund99), .sec59(sec59),
        .alarm_flag(alarm_flag), .alarm_irq_n(alarm_irq_n)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_flag(input string req, input logic exp);
        check(req, {7'd0, alarm_flag}, {7'd0, exp});
        check(req, {7'd0, alarm_irq_n}, {7'd0, !exp});
    endtask

    // one bus cycle; read data is checked before the edge
    task automatic bus(input logic wr, input logic [1:0] a, input logic [7:0] d,
                       input bit chk_rd, input logic [7:0] exp_rd, input string req);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
        #1;
        if (chk_rd) check(req, bus_rdata, exp_rd);
        @(posedge clk); #1;
        bus_en = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic win(input logic h, input logic s,
                       input logic [6:0] m, input logic [6:0] hr, input logic [2:0] dy);
        @(negedge clk);
        hund99 = h; sec59 = s; cur_min = m; cur_hour = hr; cur_day = dy;
        @(posedge clk); #1;
    endtask

    task automatic idle();
        @(negedge clk);
        hund99 = 1'b0; sec59 = 1'b0;
        @(posedge clk); #1;
    endtask

    initial begin
        #2_000_000;
        if (!ended) begin
            ended = 1;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R10 reset state
        check_flag("R10 flag after reset", 1'b0);
        for (int a = 0; a < 3; a++) begin
            bus_addr = a[1:0]; #1;
            check("R10 reg after reset", bus_rdata, 8'h00);
        end
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;

        // R1/R2 readback
        bus(1'b1, 2'd2, 8'hFF, 0, 8'h00, "");
        bus(1'b0, 2'd2, 8'h00, 1, 8'h87, "R2 day pad bits read zero");
        bus(1'b1, 2'd0, 8'hD9, 0, 8'h00, "");
        bus(1'b0, 2'd0, 8'h00, 1, 8'hD9, "R1 minutes readback");
        bus(1'b1, 2'd1, 8'h7F, 0, 8'h00, "");
        bus(1'b0, 2'd1, 8'h00, 1, 8'h7F, "R1 hours readback");
        bus(1'b1, 2'd3, 8'hAA, 0, 8'h00, "");
        bus(1'b0, 2'd3, 8'h00, 1, 8'h00, "R9 address 3 reads zero");

        // R3..R6 sweep: all mask combos x all match patterns
        for (int mk = 0; mk < 8; mk++) begin
            logic dm, hm, mm;
            dm = mk[2]; hm = mk[1]; mm = mk[0];
            bus(1'b1, 2'd0, {mm, 7'h30}, 0, 8'h00, "");
            bus(1'b1, 2'd1, {hm, 7'h52}, 0, 8'h00, "");
            bus(1'b1, 2'd2, {dm, 4'h0, 3'd3}, 0, 8'h00, "");
            bus(1'b0, 2'd0, 8'h00, 1, {mm, 7'h30}, "R1 min sweep readback");
            bus(1'b0, 2'd1, 8'h00, 1, {hm, 7'h52}, "R1 hour sweep readback");
            bus(1'b0, 2'd2, 8'h00, 1, {dm, 4'h0, 3'd3}, "R2 day sweep readback");
            for (int p = 0; p < 8; p++) begin
                logic em, eh, ed, exp_fire;
                em = p[0]; eh = p[1]; ed = p[2];
                exp_fire = (dm || ed) && ((dm && hm) || eh) && ((dm && hm && mm) || em);
                win(1'b1, 1'b1, em ? 7'h30 : 7'h31, eh ? 7'h52 : 7'h12, ed ? 3'd3 : 3'd4);
                idle();
                if (!dm)            check_flag("R3 full compare", exp_fire);
                else if (!hm)       check_flag("R4 daily", exp_fire);
                else if (!mm)       check_flag("R5 hourly", exp_fire);
                else                check_flag("R6 every minute", exp_fire);
                bus(1'b0, 2'd1, 8'h00, 0, 8'h00, "");
                check_flag("R9 read clears", 1'b0);
            end
        end

        // now all masks set (last sweep): window gating
        win(1'b1, 1'b0, 7'h00, 7'h00, 3'd0);
        idle();
        check_flag("R7 no check without sec59", 1'b0);
        win(1'b0, 1'b1, 7'h00, 7'h00, 3'd0);
        idle();
        check_flag("R7 no check without hund99", 1'b0);

        // R7 once per window: clear mid window, no refire
        win(1'b1, 1'b1, 7'h00, 7'h00, 3'd0);
        check_flag("R7 fires at window edge", 1'b1);
        @(negedge clk); bus_en = 1'b1; bus_wr = 1'b0; bus_addr = 2'd0;
        @(posedge clk); #1; bus_en = 1'b0;
        check_flag("R9 clear inside window", 1'b0);
        win(1'b1, 1'b1, 7'h00, 7'h00, 3'd0);
        win(1'b1, 1'b1, 7'h00, 7'h00, 3'd0);
        check_flag("R7 no refire in same window", 1'b0);
        idle();
        win(1'b1, 1'b1, 7'h00, 7'h00, 3'd0);
        check_flag("R7 fires in next window", 1'b1);

        // R8 sticky
        repeat (5) idle();
        check_flag("R8 flag sticky", 1'b1);

        // R9 address 3 does not clear
        bus(1'b1, 2'd3, 8'h55, 0, 8'h00, "");
        check_flag("R9 address 3 leaves flag", 1'b1);
        bus(1'b1, 2'd2, 8'h83, 0, 8'h00, "");
        check_flag("R9 write clears", 1'b0);

        // R9 access wins over same-cycle hit
        idle();
        @(negedge clk);
        hund99 = 1'b1; sec59 = 1'b1;
        bus_en = 1'b1; bus_wr = 1'b0; bus_addr = 2'd2;
        @(posedge clk); #1; bus_en = 1'b0;
        check_flag("R9 access beats hit", 1'b0);
        win(1'b1, 1'b1, 7'h00, 7'h00, 3'd0);
        check_flag("R7 suppressed hit used the window", 1'b0);
        idle();

        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule